// File: doc/BRIEF.md
# Radix-2^2 Delay-Feedback FFT Stage

This block is one stage of a pipelined fast Fourier transform built from single-path delay feedback butterflies. It takes a stream of complex fixed-point samples, one per valid cycle, and processes each sub-transform of length M = 2^(LOG2N - 2*STAGE). Two butterflies run in cascade. The first pairs samples M/2 apart. The second pairs samples M/4 apart and applies a multiplier-free rotation by -j to its lower operand in the second half of each block. A complex multiplier then applies the twiddle factors that the next stage expects.

Each butterfly keeps its own feedback memory and its own count of accepted samples. Only cycles with `in_valid` high advance the stage, so the input stream may have gaps. Per-butterfly halving can be switched on, which keeps the word length fixed. With halving off, each butterfly adds one bit. A parameter selects a multiplier built from four or from three real products. Both give identical results.

Top module: `r22_sdf_stage`

## Requirements
- R1: A synchronous active-high `rst` clears the stage. In the cycle after reset, `out_valid` is 0 and `out_re`/`out_im` are 0. No output is valid until 3M/4 new valid samples have been accepted.
- R2: For an input block x[0..M-1], with h = M/2, the first butterfly forms a[n] = x[n] + x[n+h] and b[n] = x[n] - x[n+h]. Within each output block of M samples, the a-values feed the first half and the b-values feed the second half.
- R3: For each n < M/4, with q = M/4, the output block is laid out as four groups in this order: a[n]+a[n+q], a[n]-a[n+q], b[n]+(-j)b[n+q], b[n]-(-j)b[n+q]. Here (-j)(u+jv) = v - ju.
- R4: Group g (0..3) at position n is multiplied by W = cos(2*pi*e/M) - j*sin(2*pi*e/M), where e = n*k and k is 0, 2, 1, 3 for g = 0, 1, 2, 3. Each twiddle part is round(value * 2^(WL-2)) in WL bits. Each product part is rounded half-up at bit WL-2, shifted right by WL-2 and saturated to the output width.
- R5: With SCALE=1, each butterfly result is shifted right by one bit with floor rounding, and the output is WL bits wide. With SCALE=0, there is no shift and the output is WL+2 bits wide.
- R6: MULT3=1 (three products) gives bit-identical output to MULT3=0 (four products).
- R7: Each valid input whose index since reset is at least 3M/4 produces exactly one valid output 5 cycles later. No other cycle has `out_valid` high, and cycles without `in_valid` advance nothing.
- R8: While `out_valid` is 0, `out_re` and `out_im` keep their last value.
- R9: A reset in the middle of a block discards the partial block. The sample accepted first after the reset is position 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_re | input | WL | Input real part, signed |
| in_im | input | WL | Input imaginary part, signed |
| out_valid | output | 1 | Output sample valid |
| out_re | output | WL or WL+2 | Output real part, signed (width set by SCALE) |
| out_im | output | WL or WL+2 | Output imaginary part, signed (width set by SCALE) |

## Verification
The bench drives two configurations side by side.

- **Configuration A:** length-16, unscaled, three products.
- **Configuration B:** length-64, halved, four products.

**Input patterns and the faults they expose:**
- **Random gaps in `in_valid`:** these catch a control counter that advances on idle cycles. Such a counter scrambles the group order and the twiddle choice.
- **Full-scale and square-wave blocks:** these stress bit growth and saturation. A wrong width or a missing clamp wraps a large bin to the wrong sign.
- **Reset in the middle of a block:** this catches stale counters. Stale counters show up as early valid outputs or as frames shifted by the length of the partial block.

**What a wrong design would produce:**
- A rotation applied to the wrong group, or swapped parts, corrupts only the odd bins of the second half of each block.
- An off-by-one twiddle pattern corrupts every group except the first.

// File: rtl/r22_pkg.sv
package r22_pkg;
  // Fixed-point twiddle part: value scaled by 2^(wl-2), rounded to nearest.
  // want_sin selects the imaginary part -sin(2*pi*e/m).
  function automatic int twiddle_q(int e, int m, int wl, bit want_sin);
    real ang;
    real v;
    ang = 6.283185307179586 * real'(e) / real'(m);
    v = want_sin ? -$sin(ang) : $cos(ang);
    return $rtoi($floor(v * real'(1 << (wl - 2)) + 0.5));
  endfunction
endpackage

// File: rtl/r22_sdf_bf.sv
module r22_sdf_bf #(
  parameter int IW    = 16,
  parameter int D     = 32,
  parameter int ROT   = 0,
  parameter int SCALE = 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic signed [IW-1:0]                   in_re,
  input  logic signed [IW-1:0]                   in_im,
  output logic                                   out_valid,
  output logic signed [((SCALE != 0) ? IW : IW + 1)-1:0] out_re,
  output logic signed [((SCALE != 0) ? IW : IW + 1)-1:0] out_im
);
  localparam int OW = (SCALE != 0) ? IW : IW + 1;
  localparam int SW = IW + 1;
  localparam int DL = $clog2(D);
  localparam int AW = (DL > 0) ? DL : 1;
  localparam int CW = DL + 1 + ((ROT != 0) ? 1 : 0);

  logic [CW-1:0] cnt;
  logic          primed;
  logic          sel;
  logic          rot;
  logic [AW-1:0] addr;

  logic signed [OW-1:0] mem_re [D];
  logic signed [OW-1:0] mem_im [D];
  logic signed [OW-1:0] dly_re, dly_im;
  logic signed [SW-1:0] xr, xi, dr, di, ar, ai, s_re, s_im, f_re, f_im;
  logic signed [OW-1:0] push_re, push_im, nxt_re, nxt_im;

  assign sel = cnt[DL];

  if (ROT != 0) begin : g_rot
    assign rot = cnt[CW-1];
  end else begin : g_norot
    assign rot = 1'b0;
  end

  if (DL > 0) begin : g_addr
    assign addr = cnt[AW-1:0];
  end else begin : g_addr1
    assign addr = '0;
  end

  assign dly_re = mem_re[addr];
  assign dly_im = mem_im[addr];

  assign xr = SW'(in_re);
  assign xi = SW'(in_im);
  assign dr = SW'(dly_re);
  assign di = SW'(dly_im);
  // -j on the lower operand: real takes the imaginary, imaginary takes minus real
  assign ar = rot ? xi : xr;
  assign ai = rot ? -xr : xi;

  assign s_re = dr + ar;
  assign s_im = di + ai;
  assign f_re = dr - ar;
  assign f_im = di - ai;

  assign push_re = sel ? OW'(f_re >>> SCALE) : OW'(xr);
  assign push_im = sel ? OW'(f_im >>> SCALE) : OW'(xi);
  assign nxt_re  = sel ? OW'(s_re >>> SCALE) : dly_re;
  assign nxt_im  = sel ? OW'(s_im >>> SCALE) : dly_im;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      mem_re[addr] <= push_re;
      mem_im[addr] <= push_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (in_valid) begin
      cnt       <= cnt + 1'b1;
      primed    <= primed | sel;
      out_valid <= primed | sel;
      out_re    <= nxt_re;
      out_im    <= nxt_im;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/r22_cmul.sv
module r22_cmul #(
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int MULT3 = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = DW + TW + 2;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (TW - 3);

  logic signed [PW-1:0] ar, ai, wr, wi, p_re, p_im;
  logic signed [PW-1:0] s_re, s_im, r_re, r_im;
  logic                 v1;

  assign ar = PW'(a_re);
  assign ai = PW'(a_im);
  assign wr = PW'(w_re);
  assign wi = PW'(w_im);

  if (MULT3 != 0) begin : g_three
    logic signed [PW-1:0] k1, k2, k3;
    assign k1   = wr * (ar + ai);
    assign k2   = ar * (wi - wr);
    assign k3   = ai * (wr + wi);
    assign p_re = k1 - k3;
    assign p_im = k1 + k2;
  end else begin : g_four
    assign p_re = ar * wr - ai * wi;
    assign p_im = ar * wi + ai * wr;
  end

  function automatic logic signed [DW-1:0] clamp(logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  assign r_re = (s_re + RND) >>> (TW - 2);
  assign r_im = (s_im + RND) >>> (TW - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      s_re      <= '0;
      s_im      <= '0;
      out_valid <= 1'b0;
      y_re      <= '0;
      y_im      <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        s_re <= p_re;
        s_im <= p_im;
      end
      if (v1) begin
        y_re <= clamp(r_re);
        y_im <= clamp(r_im);
      end
    end
  end
endmodule

// File: rtl/r22_sdf_stage.sv
module r22_sdf_stage #(
  parameter int LOG2N = 6,
  parameter int STAGE = 0,
  parameter int WL    = 16,
  parameter int SCALE = 1,
  parameter int MULT3 = 0
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic signed [WL-1:0]                         in_re,
  input  logic signed [WL-1:0]                         in_im,
  output logic                                         out_valid,
  output logic signed [((SCALE != 0) ? WL : WL + 2)-1:0] out_re,
  output logic signed [((SCALE != 0) ? WL : WL + 2)-1:0] out_im
);
  import r22_pkg::*;

  localparam int L  = LOG2N - 2 * STAGE;
  localparam int M  = 1 << L;
  localparam int Q  = M / 4;
  localparam int W1 = (SCALE != 0) ? WL : WL + 1;
  localparam int OW = (SCALE != 0) ? WL : WL + 2;

  logic                 b1_v, b2_v;
  logic signed [W1-1:0] b1_re, b1_im;
  logic signed [OW-1:0] b2_re, b2_im;

  r22_sdf_bf #(.IW(WL), .D(M/2), .ROT(0), .SCALE(SCALE)) u_bf1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(b1_v), .out_re(b1_re), .out_im(b1_im)
  );

  r22_sdf_bf #(.IW(W1), .D(Q), .ROT(1), .SCALE(SCALE)) u_bf2 (
    .clk(clk), .rst(rst), .in_valid(b1_v), .in_re(b1_re), .in_im(b1_im),
    .out_valid(b2_v), .out_re(b2_re), .out_im(b2_im)
  );

  // twiddle selection from the position within the block
  logic [L-1:0] tw_cnt;
  logic [L-1:0] tw_idx;
  assign tw_idx = L'((int'(tw_cnt) % Q) * int'({tw_cnt[L-2], tw_cnt[L-1]}));

  logic signed [WL-1:0] rom_re [M];
  logic signed [WL-1:0] rom_im [M];
  for (genvar i = 0; i < M; i++) begin : g_rom
    assign rom_re[i] = WL'(twiddle_q(i, M, WL, 1'b0));
    assign rom_im[i] = WL'(twiddle_q(i, M, WL, 1'b1));
  end

  logic                 a_v;
  logic signed [OW-1:0] a_re, a_im;
  logic signed [WL-1:0] w_re, w_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_cnt <= '0;
      a_v    <= 1'b0;
      a_re   <= '0;
      a_im   <= '0;
      w_re   <= '0;
      w_im   <= '0;
    end else begin
      a_v <= b2_v;
      if (b2_v) begin
        tw_cnt <= tw_cnt + 1'b1;
        a_re   <= b2_re;
        a_im   <= b2_im;
        w_re   <= rom_re[tw_idx];
        w_im   <= rom_im[tw_idx];
      end
    end
  end

  r22_cmul #(.DW(OW), .TW(WL), .MULT3(MULT3)) u_mul (
    .clk(clk), .rst(rst), .in_valid(a_v),
    .a_re(a_re), .a_im(a_im), .w_re(w_re), .w_im(w_im),
    .out_valid(out_valid), .y_re(out_re), .y_im(out_im)
  );
endmodule

// File: rtl/r22_sdf_stage_chk.sv
module r22_sdf_stage_chk #(
  parameter int OW = 16,
  parameter int TH = 48
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im
);
  localparam int CW = $clog2(TH + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid && seen != CW'(TH)) seen <= seen + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_re == '0 && out_im == '0));

  p_out_needs_in_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 5));

  p_in_gives_out_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seen == CW'(TH)) |-> ##5 out_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_re) && $stable(out_im)));
endmodule

bind r22_sdf_stage r22_sdf_stage_chk #(.OW(OW), .TH(3 * M / 4)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/r22_sdf_stage_test.sv
`timescale 1ns/1ps
module r22_sdf_stage_test;
  localparam int WL = 12;
  localparam int MA = 16;   // uut: LOG2N=6, STAGE=1
  localparam int MB = 64;   // uut_b: LOG2N=6, STAGE=0

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b0;
  logic signed [WL-1:0] din_re = '0, din_im = '0;

  logic                 ov_a, ov_b;
  logic signed [WL+1:0] oa_re, oa_im;
  logic signed [WL-1:0] ob_re, ob_im;

  always #2.5 clk = ~clk;

  r22_sdf_stage #(.LOG2N(6), .STAGE(1), .WL(WL), .SCALE(0), .MULT3(1)) uut (
    .clk(clk), .rst(rst), .in_valid(vin), .in_re(din_re), .in_im(din_im),
    .out_valid(ov_a), .out_re(oa_re), .out_im(oa_im));

  r22_sdf_stage #(.LOG2N(6), .STAGE(0), .WL(WL), .SCALE(1), .MULT3(0)) uut_b (
    .clk(clk), .rst(rst), .in_valid(vin), .in_re(din_re), .in_im(din_im),
    .out_valid(ov_b), .out_re(ob_re), .out_im(ob_im));

  int xr [4096];
  int xi [4096];
  int idx = 0;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  bit     ev  [2][8];
  longint ere [2][8];
  longint eim [2][8];
  longint hre [2];
  longint him [2];

  function automatic longint scl(longint v, bit sc);
    return sc ? (v >>> 1) : v;
  endfunction

  function automatic longint sat(longint v, int ow);
    longint hi, lo;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint twq(int e, int m, bit s);
    real ang, v;
    ang = 6.283185307179586 * real'(e) / real'(m);
    v = s ? -$sin(ang) : $cos(ang);
    return longint'($rtoi($floor(v * real'(1 << (WL - 2)) + 0.5)));
  endfunction

  // expected k-th output for block length m, from the requirement formulas
  task automatic calc(input int m, input bit sc, input int ow, input int k,
                      output longint yr, output longint yi);
    int base, q, h, r, g, n, kp, e;
    longint u0r, u0i, u1r, u1i, tr, ti, wr, wi, pr, pi;
    q = m / 4; h = m / 2; base = (k / m) * m; r = k % m; g = r / q; n = r % q;
    if (g < 2) begin
      u0r = scl(xr[base+n] + xr[base+n+h], sc);     u0i = scl(xi[base+n] + xi[base+n+h], sc);
      u1r = scl(xr[base+n+q] + xr[base+n+q+h], sc); u1i = scl(xi[base+n+q] + xi[base+n+q+h], sc);
    end else begin
      u0r = scl(xr[base+n] - xr[base+n+h], sc);     u0i = scl(xi[base+n] - xi[base+n+h], sc);
      tr  = scl(xr[base+n+q] - xr[base+n+q+h], sc); ti  = scl(xi[base+n+q] - xi[base+n+q+h], sc);
      u1r = ti; u1i = -tr;   // times -j
    end
    if (g == 0 || g == 2) begin
      tr = scl(u0r + u1r, sc); ti = scl(u0i + u1i, sc);
    end else begin
      tr = scl(u0r - u1r, sc); ti = scl(u0i - u1i, sc);
    end
    kp = (g == 0) ? 0 : (g == 1) ? 2 : (g == 2) ? 1 : 3;
    e = n * kp;
    wr = twq(e, m, 1'b0); wi = twq(e, m, 1'b1);
    pr = tr * wr - ti * wi;
    pi = tr * wi + ti * wr;
    yr = sat((pr + (longint'(1) <<< (WL - 3))) >>> (WL - 2), ow);
    yi = sat((pi + (longint'(1) <<< (WL - 3))) >>> (WL - 2), ow);
  endtask

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int s;
    bit av;
    longint ar, ai;
    s = cyc % 8;
    for (int i = 0; i < 2; i++) begin
      av = (i == 0) ? ov_a : ov_b;
      ar = (i == 0) ? longint'(oa_re) : longint'(ob_re);
      ai = (i == 0) ? longint'(oa_im) : longint'(ob_im);
      chk(av == ev[i][s], $sformatf("inst%0d out_valid (R7)", i), av, ev[i][s]);
      if (ev[i][s]) begin
        hre[i] = ere[i][s]; him[i] = eim[i][s];
        chk(ar == hre[i], $sformatf("inst%0d re (R2 R3 R4 R5 R6)", i), ar, hre[i]);
        chk(ai == him[i], $sformatf("inst%0d im (R2 R3 R4 R5 R6)", i), ai, him[i]);
      end else begin
        chk(ar == hre[i], $sformatf("inst%0d held re (R8)", i), ar, hre[i]);
        chk(ai == him[i], $sformatf("inst%0d held im (R8)", i), ai, him[i]);
      end
      ev[i][s] = 1'b0;
    end
  endtask

  task automatic step(bit r, bit v, int re, int im);
    longint yr, yi;
    int m, s5;
    @(negedge clk);
    compare();
    rst = r; vin = v; din_re = WL'(re); din_im = WL'(im);
    s5 = (cyc + 5) % 8;
    if (r) begin
      idx = 0;
      for (int i = 0; i < 2; i++) begin
        hre[i] = 0; him[i] = 0;
        for (int j = 0; j < 8; j++) ev[i][j] = 1'b0;
      end
    end else if (v) begin
      xr[idx] = re; xi[idx] = im;
      for (int i = 0; i < 2; i++) begin
        m = (i == 0) ? MA : MB;
        if (idx >= 3 * m / 4) begin
          if (i == 0) calc(m, 1'b0, WL + 2, idx - 3 * m / 4, yr, yi);
          else        calc(m, 1'b1, WL,     idx - 3 * m / 4, yr, yi);
          ev[i][s5] = 1'b1; ere[i][s5] = yr; eim[i][s5] = yi;
        end
      end
      idx++;
    end
    cyc++;
  endtask

  function automatic int rnd(int span);
    return int'($urandom_range(2 * span - 1)) - span;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      hre[i] = 0; him[i] = 0;
      for (int j = 0; j < 8; j++) ev[i][j] = 1'b0;
    end
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    // R2: contiguous random mid-range samples
    cur_req = "R2";
    for (int i = 0; i < 3 * MB; i++) step(0, 1, rnd(600), rnd(600));
    // R7: gaps in valid, full-range values (bit growth R5)
    cur_req = "R7";
    for (int i = 0; i < 3 * MB; ) begin
      if ($urandom_range(1) == 0) step(0, 0, rnd(2048), rnd(2048));
      else begin step(0, 1, rnd(2048), rnd(2048)); i++; end
    end
    // R4: extreme square-wave blocks to reach saturation
    cur_req = "R4";
    for (int i = 0; i < 2 * MB; i++)
      step(0, 1, ((i % 16) < 8) ? 2047 : -2048, (i % 2 == 1) ? -2048 : 2047);
    // R9: reset partway through a block, then fresh blocks
    cur_req = "R9";
    for (int i = 0; i < 37; i++) step(0, 1, rnd(1500), rnd(1500));
    step(1, 1, 5, 5);
    step(1, 0, 0, 0);
    for (int i = 0; i < 2 * MB; i++) step(0, 1, rnd(1500), rnd(1500));
    // R8: idle cycles, outputs must hold
    cur_req = "R8";
    for (int i = 0; i < 12; i++) step(0, 0, rnd(2048), rnd(2048));
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule